// File: doc/BRIEF.md
# DMA Controller Register Bank

This block is the processor-facing programming interface of a four-channel DMA controller. A host reaches it through an 8-bit data bus and a 4-bit port offset, using one-cycle read and write strobes. Each channel has a 16-bit address pair and a 16-bit count pair, and each pair holds a base copy and a current copy. Because the bus is eight bits wide, each 16-bit value goes through a single port in two accesses. A byte-pointer flip-flop shared by every channel picks the low byte first and the high byte second.

The upper half of the offset space holds the command and status registers, the request bits, the mask bits and the per-channel mode fields. It also holds several write-only strobes: byte-pointer clear, master clear, and whole-mask clear or load. The bank exports every stored value to a transfer engine outside the block. The engine can reload current address and count, set terminal-count flags and retire software requests.

Top module: `dmac_regbank`

## Requirements
- R1: After reset the mask bits are all 1 (mask_o = 0xF), command, request and terminal-count bits are 0, mode fields are 0, and the byte pointer selects the low byte.
- R2: A write to offset 2n (address) or 2n+1 (count) of channel n loads the byte selected by the pointer into both the base and the current copy. Pointer clear selects bits 7:0; pointer set selects bits 15:8.
- R3: A read of offsets 0..7 returns the byte of the current copy selected by the pointer. Every read or write of offsets 0..7 toggles the single shared pointer.
- R4: A write to offset 0xC clears the pointer whatever the data byte holds.
- R5: A read of offset 8 returns {request[3:0], tc[3:0]}, with channel 0 in the lowest bit of each nibble. A pulse on eng_tc_set sets the matching tc bit, which stays set until master clear or reset.
- R6: A write to offset 9 sets (data bit 2 = 1) or clears (bit 2 = 0) the request bit of the channel in data bits 1:0. eng_req_clr clears request bits. A processor write to the same bit in the same cycle wins.
- R7: A write to offset 0xA sets or clears the one mask bit selected by data bits 1:0, according to data bit 2.
- R8: A write to offset 0xB stores data bits 7:2 as the 6-bit mode field of the channel in data bits 1:0.
- R9: A write to offset 0xD zeroes command, request and tc, clears the pointer and sets all mask bits. Address, count and mode contents are unchanged.
- R10: A write to offset 0xF loads mask_o from data bits 3:0. A write to offset 0xE clears all mask bits.
- R11: A read of offsets 9..0xF returns 0x00 and changes no state, and in particular it does not toggle the pointer.
- R12: eng_ld[n] loads channel n's current address and current count from the engine and leaves the base copies unchanged. A processor write to one of those registers in the same cycle wins for that register.
- R13: A write to offset 8 stores the whole byte in the command register (cmd_o), and the byte is not visible in the status read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | One-cycle write strobe |
| rd_en | input | 1 | One-cycle read strobe (ignored while wr_en is high) |
| port | input | 4 | Port offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid during the rd_en cycle |
| eng_ld | input | 4 | Per-channel load of current address and count |
| eng_addr | input | 64 | Engine current-address values, channel n at [16n+15:16n] |
| eng_cnt | input | 64 | Engine current-count values, same packing |
| eng_tc_set | input | 4 | Per-channel terminal-count set pulses |
| eng_req_clr | input | 4 | Per-channel software request clear pulses |
| base_addr_o | output | 64 | Base address copies |
| cur_addr_o | output | 64 | Current address copies |
| base_cnt_o | output | 64 | Base count copies |
| cur_cnt_o | output | 64 | Current count copies |
| mode_o | output | 24 | Mode fields, channel n at [6n+5:6n] |
| mask_o | output | 4 | Mask bits |
| req_o | output | 4 | Software request bits |
| cmd_o | output | 8 | Command register |

## Verification
The most damaging hidden fault is a byte pointer out of step with the host. It shows at the ports on the next address or count access, as swapped bytes in rdata or as a byte landing in the wrong half of base_addr_o or cur_addr_o. A read of a write-only offset that toggled the pointer would therefore show up one access later. Mask, mode, request and command faults appear on the exported vectors one clock after the write. Terminal-count faults appear on the next status read.

// File: rtl/dmac_pkg.sv
// Shared constants and types for the DMA register bank.
// Assumes four channels selected by a 2-bit field in the data byte.
package dmac_pkg;
    localparam int NCH   = 4;
    localparam int CH_W  = $clog2(NCH);

    // Offsets whose decode the rest of the block depends on.
    typedef enum logic [3:0] {
        OFS_CMD_STAT = 4'h8,
        OFS_REQ      = 4'h9,
        OFS_MASK_ONE = 4'hA,
        OFS_MODE     = 4'hB,
        OFS_PTR_CLR  = 4'hC,
        OFS_MCLR     = 4'hD,
        OFS_MASK_CLR = 4'hE,
        OFS_MASK_ALL = 4'hF
    } ofs_e;

    // One-cycle strobes for the control side, produced by the decoder.
    typedef struct packed {
        logic cmd_wr;
        logic req_wr;
        logic mask_one;
        logic mode_wr;
        logic ptr_clr;
        logic mclr;
        logic mask_clr;
        logic mask_all;
    } ctl_strb_t;
endpackage

// File: rtl/dmac_decode.sv
// Port decoder: turns the strobes and the offset into per-register
// write enables and side-effect pulses. Assumes at most one access per
// cycle; a write takes priority over a simultaneous read.
module dmac_decode
    import dmac_pkg::*;
(
    input  logic            wr_en,
    input  logic            rd_en,
    input  logic [3:0]      port,
    output logic [NCH-1:0]  wr_addr,
    output logic [NCH-1:0]  wr_cnt,
    output logic            chan_acc,
    output logic            rd_act,
    output ctl_strb_t       strb
);
    logic is_chan;
    logic [CH_W-1:0] ch;

    assign is_chan = (port[3] == 1'b0);
    assign ch      = port[CH_W:1];
    assign rd_act  = rd_en & ~wr_en;

    // Channel register write enables, one per channel and kind.
    always_comb begin
        wr_addr = '0;
        wr_cnt  = '0;
        if (wr_en && is_chan) begin
            if (port[0]) wr_cnt[ch]  = 1'b1;
            else         wr_addr[ch] = 1'b1;
        end
    end

    // Any address/count access moves the shared byte pointer.
    assign chan_acc = is_chan & (wr_en | rd_act);

    // Control-side strobes; only writes have side effects.
    always_comb begin
        strb = '0;
        if (wr_en) begin
            case (port)
                OFS_CMD_STAT: strb.cmd_wr   = 1'b1;
                OFS_REQ:      strb.req_wr   = 1'b1;
                OFS_MASK_ONE: strb.mask_one = 1'b1;
                OFS_MODE:     strb.mode_wr  = 1'b1;
                OFS_PTR_CLR:  strb.ptr_clr  = 1'b1;
                OFS_MCLR:     strb.mclr     = 1'b1;
                OFS_MASK_CLR: strb.mask_clr = 1'b1;
                OFS_MASK_ALL: strb.mask_all = 1'b1;
                default:      strb = '0;
            endcase
        end
    end
endmodule

// File: rtl/dmac_chan_regs.sv
// One channel's address and count registers, each a base/current pair.
// A host write loads one byte of both copies; an engine load replaces the
// whole current copy unless the host writes that register in the same cycle.
module dmac_chan_regs #(
    parameter int DATA_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_addr,
    input  logic                wr_cnt,
    input  logic                hi_sel,
    input  logic [DATA_W-1:0]   wdata,
    input  logic                eng_ld,
    input  logic [2*DATA_W-1:0] eng_addr,
    input  logic [2*DATA_W-1:0] eng_cnt,
    output logic [2*DATA_W-1:0] base_addr,
    output logic [2*DATA_W-1:0] cur_addr,
    output logic [2*DATA_W-1:0] base_cnt,
    output logic [2*DATA_W-1:0] cur_cnt
);
    localparam int REG_W = 2 * DATA_W;

    // Replace the selected byte of a value with the host data.
    function automatic logic [REG_W-1:0] put_byte(input logic [REG_W-1:0] v,
                                                  input logic hi,
                                                  input logic [DATA_W-1:0] d);
        logic [REG_W-1:0] r;
        r = v;
        if (hi) r[REG_W-1:DATA_W] = d;
        else    r[DATA_W-1:0]     = d;
        return r;
    endfunction

    // Address pair: host byte write beats engine reload.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_addr <= '0;
            cur_addr  <= '0;
        end else if (wr_addr) begin
            base_addr <= put_byte(base_addr, hi_sel, wdata);
            cur_addr  <= put_byte(cur_addr, hi_sel, wdata);
        end else if (eng_ld) begin
            cur_addr  <= eng_addr;
        end
    end

    // Count pair: same precedence as the address pair.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_cnt <= '0;
            cur_cnt  <= '0;
        end else if (wr_cnt) begin
            base_cnt <= put_byte(base_cnt, hi_sel, wdata);
            cur_cnt  <= put_byte(cur_cnt, hi_sel, wdata);
        end else if (eng_ld) begin
            cur_cnt  <= eng_cnt;
        end
    end
endmodule

// File: rtl/dmac_ctrl_regs.sv
// Control side: command, terminal-count flags, requests, masks, mode
// fields and the shared byte pointer. Master clear and reset share one
// path; mode fields are kept across master clear.
module dmac_ctrl_regs
    import dmac_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  ctl_strb_t                 strb,
    input  logic                      chan_acc,
    input  logic [DATA_W-1:0]         wdata,
    input  logic [NCH-1:0]            eng_tc_set,
    input  logic [NCH-1:0]            eng_req_clr,
    output logic [DATA_W-1:0]         cmd_q,
    output logic [NCH-1:0]            tc_q,
    output logic [NCH-1:0]            req_q,
    output logic [NCH-1:0]            mask_q,
    output logic [NCH*(DATA_W-2)-1:0] mode_q,
    output logic                      ptr_q
);
    localparam int MODE_W = DATA_W - 2;

    logic            clr_all;
    logic [CH_W-1:0] sel_ch;
    logic            sel_val;
    logic [NCH-1:0]  req_nxt;

    assign clr_all = ~rst_n | strb.mclr;
    assign sel_ch  = wdata[CH_W-1:0];
    assign sel_val = wdata[CH_W];

    // Byte pointer: cleared by reset, master clear or pointer clear.
    always_ff @(posedge clk) begin
        if (clr_all || strb.ptr_clr) ptr_q <= 1'b0;
        else if (chan_acc)           ptr_q <= ~ptr_q;
    end

    // Command register.
    always_ff @(posedge clk) begin
        if (clr_all)          cmd_q <= '0;
        else if (strb.cmd_wr) cmd_q <= wdata;
    end

    // Sticky terminal-count flags.
    always_ff @(posedge clk) begin
        if (clr_all) tc_q <= '0;
        else         tc_q <= tc_q | eng_tc_set;
    end

    // Request bits: engine retires first, host write overrides.
    always_comb begin
        req_nxt = req_q & ~eng_req_clr;
        if (strb.req_wr) req_nxt[sel_ch] = sel_val;
    end

    // Request register update.
    always_ff @(posedge clk) begin
        if (clr_all) req_q <= '0;
        else         req_q <= req_nxt;
    end

    // Mask bits: single-bit, clear-all and load-all forms.
    always_ff @(posedge clk) begin
        if (clr_all)             mask_q <= '1;
        else if (strb.mask_clr)  mask_q <= '0;
        else if (strb.mask_all)  mask_q <= wdata[NCH-1:0];
        else if (strb.mask_one)  mask_q[sel_ch] <= sel_val;
    end

    // Per-channel mode fields from the upper data bits.
    for (genvar i = 0; i < NCH; i++) begin : g_mode
        always_ff @(posedge clk) begin
            if (!rst_n)
                mode_q[i*MODE_W +: MODE_W] <= '0;
            else if (strb.mode_wr && sel_ch == CH_W'(i))
                mode_q[i*MODE_W +: MODE_W] <= wdata[DATA_W-1:2];
        end
    end
endmodule

// File: rtl/dmac_regbank.sv
// Top of the DMA programming register bank. Decodes the host port,
// holds per-channel and control registers and muxes read data.
// Read data is combinational during the read strobe cycle.
module dmac_regbank
    import dmac_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int REG_W  = 2 * DATA_W,
    localparam int MODE_W = DATA_W - 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic                  rd_en,
    input  logic [3:0]            port,
    input  logic [DATA_W-1:0]     wdata,
    output logic [DATA_W-1:0]     rdata,
    input  logic [NCH-1:0]        eng_ld,
    input  logic [NCH*REG_W-1:0]  eng_addr,
    input  logic [NCH*REG_W-1:0]  eng_cnt,
    input  logic [NCH-1:0]        eng_tc_set,
    input  logic [NCH-1:0]        eng_req_clr,
    output logic [NCH*REG_W-1:0]  base_addr_o,
    output logic [NCH*REG_W-1:0]  cur_addr_o,
    output logic [NCH*REG_W-1:0]  base_cnt_o,
    output logic [NCH*REG_W-1:0]  cur_cnt_o,
    output logic [NCH*MODE_W-1:0] mode_o,
    output logic [NCH-1:0]        mask_o,
    output logic [NCH-1:0]        req_o,
    output logic [DATA_W-1:0]     cmd_o
);
    logic [NCH-1:0]  wr_addr, wr_cnt;
    logic            chan_acc, rd_act, ptr_w;
    ctl_strb_t       strb;
    logic [NCH-1:0]  tc_w;
    logic [REG_W-1:0] rd_word;
    logic [CH_W-1:0] rd_ch;

    dmac_decode u_dec (
        .wr_en(wr_en), .rd_en(rd_en), .port(port),
        .wr_addr(wr_addr), .wr_cnt(wr_cnt),
        .chan_acc(chan_acc), .rd_act(rd_act), .strb(strb)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        dmac_chan_regs #(.DATA_W(DATA_W)) u_ch (
            .clk(clk), .rst_n(rst_n),
            .wr_addr(wr_addr[c]), .wr_cnt(wr_cnt[c]),
            .hi_sel(ptr_w), .wdata(wdata),
            .eng_ld(eng_ld[c]),
            .eng_addr(eng_addr[c*REG_W +: REG_W]),
            .eng_cnt(eng_cnt[c*REG_W +: REG_W]),
            .base_addr(base_addr_o[c*REG_W +: REG_W]),
            .cur_addr(cur_addr_o[c*REG_W +: REG_W]),
            .base_cnt(base_cnt_o[c*REG_W +: REG_W]),
            .cur_cnt(cur_cnt_o[c*REG_W +: REG_W])
        );
    end

    dmac_ctrl_regs #(.DATA_W(DATA_W)) u_ctl (
        .clk(clk), .rst_n(rst_n), .strb(strb), .chan_acc(chan_acc),
        .wdata(wdata), .eng_tc_set(eng_tc_set), .eng_req_clr(eng_req_clr),
        .cmd_q(cmd_o), .tc_q(tc_w), .req_q(req_o), .mask_q(mask_o),
        .mode_q(mode_o), .ptr_q(ptr_w)
    );

    assign rd_ch = port[CH_W:1];

    // Select the current word addressed by a channel-port read.
    always_comb begin
        if (port[0]) rd_word = cur_cnt_o[rd_ch*REG_W +: REG_W];
        else         rd_word = cur_addr_o[rd_ch*REG_W +: REG_W];
    end

    // Read data mux; write-only offsets return zero.
    always_comb begin
        rdata = '0;
        if (rd_act) begin
            if (!port[3])
                rdata = ptr_w ? rd_word[REG_W-1:DATA_W] : rd_word[DATA_W-1:0];
            else if (port == OFS_CMD_STAT)
                rdata = DATA_W'({req_o, tc_w});
        end
    end
endmodule

// File: rtl/dmac_regbank_chk.sv
// Property checker for the DMA register bank, attached by bind.
// Observes ports plus the terminal-count flags.
module dmac_regbank_chk #(
    parameter int DATA_W = 8,
    parameter int NCH    = 4
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           wr_en,
    input logic                           rd_en,
    input logic [3:0]                     port,
    input logic [DATA_W-1:0]              wdata,
    input logic [DATA_W-1:0]              rdata,
    input logic [NCH-1:0]                 mask_o,
    input logic [NCH*(DATA_W-2)-1:0]      mode_o,
    input logic [NCH*2*DATA_W-1:0]        base_addr_o,
    input logic [NCH*2*DATA_W-1:0]        base_cnt_o,
    input logic [DATA_W-1:0]              cmd_o,
    input logic [NCH-1:0]                 tc_w
);
    localparam int MODE_W = DATA_W - 2;

    // R11: write-only offsets read as zero.
    p_wo_read_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && port >= 4'h9) |-> rdata == '0);

    // R9: master clear sets every mask bit and clears command.
    p_mclr_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && port == 4'hD) |=> (mask_o == '1 && cmd_o == '0 && tc_w == '0));

    // R10: load-all mask takes the low data bits.
    p_mask_all_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && port == 4'hF) |=> mask_o == $past(wdata[NCH-1:0]));

    // R10: clear-all mask.
    p_mask_clr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && port == 4'hE) |=> mask_o == '0);

    // R8: mode field of the selected channel takes data bits 7:2.
    p_mode_wr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && port == 4'hB) |=>
        mode_o[$past(wdata[1:0])*MODE_W +: MODE_W] == $past(wdata[DATA_W-1:2]));

    // R5: terminal-count flags only fall on master clear.
    p_tc_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && port == 4'hD) |=> (tc_w & $past(tc_w)) == $past(tc_w));

    // R12: base copies move only on a host write.
    p_base_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(base_addr_o) && $stable(base_cnt_o)));

    // R13: command register only changes on its own write or master clear.
    p_cmd_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && (port == 4'h8 || port == 4'hD)) |=> $stable(cmd_o));
endmodule

bind dmac_regbank dmac_regbank_chk #(.DATA_W(DATA_W), .NCH(dmac_pkg::NCH)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .port(port),
    .wdata(wdata), .rdata(rdata), .mask_o(mask_o), .mode_o(mode_o),
    .base_addr_o(base_addr_o), .base_cnt_o(base_cnt_o), .cmd_o(cmd_o),
    .tc_w(tc_w)
);

// File: tb/dmac_regbank_tb.sv
// Bench: directed corner cases plus seeded random host traffic, checked
// against a behavioural model kept in bench variables.
module dmac_regbank_tb_top;
    localparam int NCH = 4;
    localparam int RW  = 16;

    logic clk = 0;
    logic rst_n = 0;
    logic wr_en = 0, rd_en = 0;
    logic [3:0] port = 0;
    logic [7:0] wdata = 0;
    logic [7:0] rdata;
    logic [NCH-1:0] eng_ld = 0, eng_tc_set = 0, eng_req_clr = 0;
    logic [NCH*RW-1:0] eng_addr = 0, eng_cnt = 0;
    logic [NCH*RW-1:0] base_addr_o, cur_addr_o, base_cnt_o, cur_cnt_o;
    logic [NCH*6-1:0] mode_o;
    logic [NCH-1:0] mask_o, req_o;
    logic [7:0] cmd_o;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    dmac_regbank dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .port(port),
        .wdata(wdata), .rdata(rdata), .eng_ld(eng_ld), .eng_addr(eng_addr),
        .eng_cnt(eng_cnt), .eng_tc_set(eng_tc_set), .eng_req_clr(eng_req_clr),
        .base_addr_o(base_addr_o), .cur_addr_o(cur_addr_o),
        .base_cnt_o(base_cnt_o), .cur_cnt_o(cur_cnt_o), .mode_o(mode_o),
        .mask_o(mask_o), .req_o(req_o), .cmd_o(cmd_o)
    );

    // Behavioural model state.
    logic [15:0] m_ba[NCH], m_ca[NCH], m_bc[NCH], m_cc[NCH];
    logic [5:0]  m_mode[NCH];
    logic [3:0]  m_mask, m_req, m_tc;
    logic [7:0]  m_cmd;
    logic        m_ptr;

    function automatic void m_reset();
        for (int c = 0; c < NCH; c++) begin
            m_ba[c] = 0; m_ca[c] = 0; m_bc[c] = 0; m_cc[c] = 0; m_mode[c] = 0;
        end
        m_mask = 4'hF; m_req = 0; m_tc = 0; m_cmd = 0; m_ptr = 0;
    endfunction

    function automatic logic [15:0] setb(logic [15:0] v, logic hi, logic [7:0] d);
        if (hi) return {d, v[7:0]};
        return {v[15:8], d};
    endfunction

    function automatic void m_write(logic [3:0] p, logic [7:0] d);
        int c;
        c = p[2:1];
        case (p)
            4'h0, 4'h1, 4'h2, 4'h3, 4'h4, 4'h5, 4'h6, 4'h7: begin
                if (p[0]) begin
                    m_bc[c] = setb(m_bc[c], m_ptr, d); m_cc[c] = setb(m_cc[c], m_ptr, d);
                end else begin
                    m_ba[c] = setb(m_ba[c], m_ptr, d); m_ca[c] = setb(m_ca[c], m_ptr, d);
                end
                m_ptr = ~m_ptr;
            end
            4'h8: m_cmd = d;
            4'h9: m_req[d[1:0]] = d[2];
            4'hA: m_mask[d[1:0]] = d[2];
            4'hB: m_mode[d[1:0]] = d[7:2];
            4'hC: m_ptr = 0;
            4'hD: begin m_cmd = 0; m_req = 0; m_tc = 0; m_ptr = 0; m_mask = 4'hF; end
            4'hE: m_mask = 0;
            default: m_mask = d[3:0];
        endcase
    endfunction

    function automatic logic [7:0] m_read(logic [3:0] p);
        logic [15:0] w;
        int c;
        c = p[2:1];
        if (!p[3]) begin
            w = p[0] ? m_cc[c] : m_ca[c];
            m_ptr = ~m_ptr;
            return m_ptr ? w[7:0] : w[15:8];
        end
        if (p == 4'h8) return {m_req, m_tc};
        return 8'h00;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Host write; entered just after a rising edge.
    task automatic do_wr(input logic [3:0] p, input logic [7:0] d);
        port = p; wdata = d; wr_en = 1;
        @(posedge clk); #1;
        wr_en = 0;
        m_write(p, d);
    endtask

    // Host read with check of the returned byte.
    task automatic do_rd(input logic [3:0] p, input string req);
        logic [7:0] e;
        port = p; rd_en = 1;
        @(negedge clk);
        e = m_read(p);
        chk(req, rdata, e);
        @(posedge clk); #1;
        rd_en = 0;
    endtask

    task automatic chk_exports(input string tag);
        chk({tag, " R10 mask"}, mask_o, m_mask);
        chk({tag, " R13 cmd"}, cmd_o, m_cmd);
        chk({tag, " R6 req"}, req_o, m_req);
        for (int c = 0; c < NCH; c++) begin
            chk({tag, " R8 mode"}, mode_o[c*6 +: 6], m_mode[c]);
            chk({tag, " R2 base addr"}, base_addr_o[c*RW +: RW], m_ba[c]);
            chk({tag, " R2 cur addr"}, cur_addr_o[c*RW +: RW], m_ca[c]);
            chk({tag, " R2 base cnt"}, base_cnt_o[c*RW +: RW], m_bc[c]);
            chk({tag, " R2 cur cnt"}, cur_cnt_o[c*RW +: RW], m_cc[c]);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        m_reset();
        void'($urandom(32'h1c3a5e77));
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(posedge clk); #1;

        // R1: reset state.
        chk("R1 mask", mask_o, 4'hF);
        chk("R1 cmd", cmd_o, 0);
        chk("R1 req", req_o, 0);
        chk("R1 mode", mode_o, 0);
        do_rd(4'h8, "R1 status");

        // R2/R3: program channel 2 address and count, read back.
        do_wr(4'h4, 8'h34); do_wr(4'h4, 8'h12);
        do_wr(4'h5, 8'hCD); do_wr(4'h5, 8'hAB);
        chk("R2 ch2 addr", cur_addr_o[2*RW +: RW], 16'h1234);
        chk("R2 ch2 cnt base", base_cnt_o[2*RW +: RW], 16'hABCD);
        do_rd(4'h4, "R3 low"); do_rd(4'h4, "R3 high");
        // R3: pointer is shared across ports.
        do_rd(4'h5, "R3 shared low"); do_rd(4'h4, "R3 shared high");

        // R11: write-only read returns zero and does not toggle pointer.
        do_rd(4'h5, "R3 low before R11");
        do_rd(4'hB, "R11 zero");
        do_rd(4'hF, "R11 zero F");
        do_rd(4'h5, "R11 pointer unchanged");

        // R4: pointer clear ignores data.
        do_wr(4'h0, 8'h77);
        do_wr(4'hC, 8'hFF);
        do_rd(4'h0, "R4 low after clear");
        do_wr(4'hC, 8'h00);

        // R13: command byte.
        do_wr(4'h8, 8'hA5);
        chk("R13 cmd", cmd_o, 8'hA5);
        do_rd(4'h8, "R13 status not cmd");

        // R6/R7/R8/R10.
        do_wr(4'h9, 8'h07); do_wr(4'h9, 8'h05);
        chk("R6 req", req_o, 4'b1010);
        do_wr(4'hE, 8'hFF);
        chk("R10 clear all", mask_o, 4'h0);
        do_wr(4'hA, 8'h06);
        chk("R7 single", mask_o, 4'b0100);
        do_wr(4'hF, 8'hF9);
        chk("R10 load all", mask_o, 4'h9);
        do_wr(4'hB, 8'hDB);
        chk("R8 mode ch3", mode_o[18 +: 6], 6'h36);

        // R5: terminal count flags, status layout.
        eng_tc_set = 4'b0101; @(posedge clk); #1; eng_tc_set = 0;
        m_tc = 4'b0101;
        do_rd(4'h8, "R5 status");

        // R6: engine retire vs host write in the same cycle.
        eng_req_clr = 4'b1010;
        port = 4'h9; wdata = 8'h07; wr_en = 1;
        @(posedge clk); #1; wr_en = 0; eng_req_clr = 0;
        m_req = 4'b1000;
        chk("R6 host wins", req_o, 4'b1000);

        // R12: engine load, host write to address wins.
        do_wr(4'hC, 8'h00);
        eng_ld = 4'b0001; eng_addr[15:0] = 16'hBEEF; eng_cnt[15:0] = 16'h4321;
        port = 4'h0; wdata = 8'h55; wr_en = 1;
        @(posedge clk); #1; wr_en = 0; eng_ld = 0;
        m_write(4'h0, 8'h55);
        m_cc[0] = 16'h4321;
        chk("R12 cnt from engine", cur_cnt_o[15:0], 16'h4321);
        chk("R12 base cnt kept", base_cnt_o[15:0], m_bc[0]);
        chk("R12 host addr wins", cur_addr_o[15:0], m_ca[0]);
        eng_ld = 4'b0010; eng_addr[31:16] = 16'h0F0F; eng_cnt[31:16] = 16'h00FF;
        @(posedge clk); #1; eng_ld = 0;
        m_ca[1] = 16'h0F0F; m_cc[1] = 16'h00FF;
        chk_exports("R12 engine");

        // R9: master clear.
        do_wr(4'h0, 8'h11);
        do_wr(4'hD, 8'h00);
        chk_exports("R9 mclr");
        do_rd(4'h8, "R9 status");
        do_rd(4'h2, "R9 pointer low");

        // Random traffic.
        for (int i = 0; i < 2000; i++) begin
            logic [3:0] p;
            p = 4'($urandom % 16);
            if (p == 4'hD && ($urandom % 4) != 0) p = 4'h9;
            if ($urandom % 2) do_wr(p, 8'($urandom));
            else              do_rd(p, "R3 R11 random read");
            if (i % 100 == 99) chk_exports("R2 random");
        end

        finish_run();
    end
endmodule